// File: doc/BRIEF.md
# Vanishing-Point Centred Hough Line Detector

This block finds straight lane boundaries that run through a known vanishing point. While a frame window is open it numbers the incoming edge pixels by column and row. Each pixel marked as an edge goes into an on-chip point list as an (x, y) pair, so the block never holds a bitmap. When the window closes, the block latches the vanishing point and shifts every stored point so that this point is the origin. For each angle bin it then forms the normal distance ρ = dx·cos θ + dy·sin θ. A bin earns a vote only when |ρ| is within a small tolerance of zero. A line through the origin has ρ = 0, so one vote counter per angle replaces the usual two-dimensional (ρ, θ) array. Lines that miss the vanishing point collect nothing.

The angle bins are split across parallel lanes. Each lane owns a dual-port counter RAM: one port reads a count and the other writes back the incremented value a cycle later. A bypass path covers the case where the next point reads the counter still being written. After voting the block walks the bins in ascending order. It reports each bin whose count reaches the threshold, zeroes the counters as it passes them, and ends with a done pulse. The surrounding software picks lane candidates from the reported list.

Top module: `hvd_line_detector`

## Requirements
- R1: After reset, busy_o, ovf_o, res_valid_o and done_o are all low, and every vote counter starts at zero.
- R2: A rising edge on frame_i while idle opens a frame. Each cycle with frame_i and de_i high advances the pixel position: x counts 0..IMG_W-1 and then wraps, which increments y. A pixel with edge_i high is stored as the point (x, y). frame_i going low closes the frame and starts voting.
- R3: Bin k has angle kπ/NBINS, with C = round(511·cos) and S = round(511·sin). A stored point votes for bin k when |dx·C + dy·S| ≤ 512·tol_i + 256, where dx = x − vx and dy = y − vy.
- R4: Each bin's final count equals the number of stored points that vote for it. No increment is lost when consecutive points update the same counter.
- R5: After voting, bins are reported in ascending index order. Each bin with count ≥ thr_i gives one cycle of res_valid_o carrying res_bin_o = k and res_count_o = count, and a count equal to thr_i is reported. done_o pulses for one cycle after the last report.
- R6: Every frame's voting starts from zero counters. An empty frame with thr_i = 0 reports all NBINS bins with count 0.
- R7: busy_o rises the cycle after a frame closes and stays high until done_o. A frame_i rise while busy is ignored, and pixels arriving then are not stored.
- R8: At most MAX_PTS points are stored per frame. Any further edge pixel is dropped and sets ovf_o. ovf_o stays high until the next accepted frame start clears it.
- R9: The vanishing point (vp_x_i, vp_y_i) is sampled on the cycle the frame closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Frame window, high while a frame is delivered |
| de_i | input | 1 | Pixel valid |
| edge_i | input | 1 | Binary edge value of the pixel |
| vp_x_i | input | X_W | Vanishing point column |
| vp_y_i | input | Y_W | Vanishing point row |
| tol_i | input | 3 | Distance tolerance in pixels |
| thr_i | input | CNT_W | Report threshold |
| busy_o | output | 1 | Voting or reporting in progress |
| ovf_o | output | 1 | Sticky point-list overflow |
| res_valid_o | output | 1 | Reported bin valid |
| res_bin_o | output | BIN_W | Reported angle bin index |
| res_count_o | output | CNT_W | Reported vote count |
| done_o | output | 1 | One-cycle end of report |

## Verification
The bench builds a 16×16 image with 16 angle bins, 16 lanes and an 8-entry point list. With 16 lanes there is one bin per lane, so every point updates counter address 0 in each lane on consecutive cycles. The read-after-write bypass therefore carries every count. An 8-entry list lets a single row of edges overflow it. A short frame keeps the voting window brief enough for a second frame to arrive while the block is busy.

// File: rtl/hvd_pkg.sv
package hvd_pkg;
  localparam int TRIG_W   = 10;
  localparam int TRIG_ONE = 511;

  typedef logic signed [TRIG_W-1:0] trig_t;
  typedef logic signed [15:0]       crd_t;
  typedef logic signed [31:0]       rho_t;

  typedef enum logic [2:0] {
    ST_CLR, ST_IDLE, ST_CAP, ST_VOTE, ST_DRAIN, ST_SCAN, ST_FLUSH, ST_FIN
  } state_t;

  // quantised sine or cosine of bin k out of nbins over half a turn
  function automatic trig_t hvd_trig(int k, int nbins, bit want_sin);
    real ang;
    real v;
    ang = 3.141592653589793 * real'(k) / real'(nbins);
    v = want_sin ? $sin(ang) : $cos(ang);
    return trig_t'($rtoi($floor(v * real'(TRIG_ONE) + 0.5)));
  endfunction

  // normal distance scaled by TRIG_ONE
  function automatic rho_t hvd_rho(crd_t dx, crd_t dy, trig_t c, trig_t s);
    return rho_t'(dx) * rho_t'(c) + rho_t'(dy) * rho_t'(s);
  endfunction

  // half-pixel slack absorbs trig rounding
  function automatic logic hvd_near(rho_t rho, logic [2:0] tol);
    rho_t mag;
    rho_t lim;
    mag = (rho < 0) ? -rho : rho;
    lim = (rho_t'({29'd0, tol}) <<< 9) + 32'sd256;
    return mag <= lim;
  endfunction
endpackage

// File: rtl/hvd_dpram.sv
module hvd_dpram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int A_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic [A_W-1:0] rd_addr,
  output logic [W-1:0]   rd_data,
  input  logic           wr_en,
  input  logic [A_W-1:0] wr_addr,
  input  logic [W-1:0]   wr_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/hvd_lane.sv
module hvd_lane
  import hvd_pkg::*;
#(
  parameter int NBINS = 64,
  parameter int LANES = 8,
  parameter int LANE  = 0,
  parameter int CNT_W = 13,
  localparam int STEPS = NBINS / LANES,
  localparam int S_W   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [S_W-1:0]   rd_addr,
  input  crd_t             dx,
  input  crd_t             dy,
  input  logic [2:0]       tol,
  input  logic             clr_en,
  input  logic [S_W-1:0]   clr_addr,
  output logic [CNT_W-1:0] rd_data_o
);
  trig_t cos_rom [STEPS];
  trig_t sin_rom [STEPS];

  for (genvar st = 0; st < STEPS; st++) begin : g_rom
    localparam trig_t CQ = hvd_trig(LANE + st * LANES, NBINS, 1'b0);
    localparam trig_t SQ = hvd_trig(LANE + st * LANES, NBINS, 1'b1);
    assign cos_rom[st] = CQ;
    assign sin_rom[st] = SQ;
  end

  logic hit1;
  assign hit1 = hvd_near(hvd_rho(dx, dy, cos_rom[rd_addr], sin_rom[rd_addr]), tol);

  logic             s2_valid, s2_hit, fwd_q;
  logic [S_W-1:0]   s2_addr;
  logic [CNT_W-1:0] fwd_val, ram_q, cur, nxt, wr_data;
  logic             wr_en;
  logic [S_W-1:0]   wr_addr;

  assign cur       = fwd_q ? fwd_val : ram_q;
  assign nxt       = cur + CNT_W'(s2_hit);
  assign wr_en     = s2_valid | clr_en;
  assign wr_addr   = s2_valid ? s2_addr : clr_addr;
  assign wr_data   = s2_valid ? nxt : '0;
  assign rd_data_o = cur;

  hvd_dpram #(.W(CNT_W), .DEPTH(STEPS)) u_acc (
    .clk(clk), .rd_addr(rd_addr), .rd_data(ram_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      fwd_q    <= 1'b0;
      s2_hit   <= 1'b0;
      s2_addr  <= '0;
      fwd_val  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_addr  <= rd_addr;
      s2_hit   <= hit1;
      fwd_q    <= wr_en && (wr_addr == rd_addr);
      fwd_val  <= wr_data;
    end
  end
endmodule

// File: rtl/hvd_line_detector.sv
module hvd_line_detector
  import hvd_pkg::*;
#(
  parameter int IMG_W   = 640,
  parameter int IMG_H   = 480,
  parameter int NBINS   = 64,
  parameter int LANES   = 8,
  parameter int MAX_PTS = 4096,
  localparam int X_W   = $clog2(IMG_W),
  localparam int Y_W   = $clog2(IMG_H),
  localparam int CNT_W = $clog2(MAX_PTS + 1),
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic             de_i,
  input  logic             edge_i,
  input  logic [X_W-1:0]   vp_x_i,
  input  logic [Y_W-1:0]   vp_y_i,
  input  logic [2:0]       tol_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             busy_o,
  output logic             ovf_o,
  output logic             res_valid_o,
  output logic [BIN_W-1:0] res_bin_o,
  output logic [CNT_W-1:0] res_count_o,
  output logic             done_o
);
  localparam int STEPS = NBINS / LANES;
  localparam int S_W   = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int L_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int A_W   = (MAX_PTS > 1) ? $clog2(MAX_PTS) : 1;

  state_t           state;
  logic             frame_q, ovf_q, v1_valid, drain, sc1_valid;
  logic [X_W-1:0]   x_q, vpx;
  logic [Y_W-1:0]   y_q, vpy;
  logic [CNT_W-1:0] npts, pidx;
  logic [S_W-1:0]   step, v1_step, cidx;
  logic [BIN_W-1:0] sidx, sc1_bin;

  // named events for the checker
  logic frame_start_evt, frame_end_evt, pix_accept, list_wr;
  assign frame_start_evt = (state == ST_IDLE) && frame_i && !frame_q;
  assign frame_end_evt   = (state == ST_CAP) && !frame_i;
  assign pix_accept      = (state == ST_CAP) && frame_i && de_i;
  assign list_wr         = pix_accept && edge_i && (npts < CNT_W'(MAX_PTS));

  assign busy_o = (state == ST_VOTE) || (state == ST_DRAIN) || (state == ST_SCAN) ||
                  (state == ST_FLUSH) || (state == ST_FIN);
  assign ovf_o  = ovf_q;

  // point list
  logic [X_W+Y_W-1:0] list_q;
  hvd_dpram #(.W(X_W + Y_W), .DEPTH(MAX_PTS)) u_list (
    .clk(clk), .rd_addr(pidx[A_W-1:0]), .rd_data(list_q),
    .wr_en(list_wr), .wr_addr(npts[A_W-1:0]), .wr_data({x_q, y_q})
  );

  crd_t dx1, dy1;
  assign dx1 = crd_t'(list_q[X_W+Y_W-1:Y_W]) - crd_t'(vpx);
  assign dy1 = crd_t'(list_q[Y_W-1:0]) - crd_t'(vpy);

  // lane addressing: bin = addr*LANES + lane
  logic [S_W-1:0]   lane_rd, sc1_addr, clr_addr;
  logic [L_W-1:0]   sc1_lane;
  logic [LANES-1:0] lane_clr;
  logic [CNT_W-1:0] lane_cnt [LANES];

  assign sc1_lane = L_W'(int'(sc1_bin) % LANES);
  assign sc1_addr = S_W'(int'(sc1_bin) / LANES);
  assign lane_rd  = (state == ST_SCAN) ? S_W'(int'(sidx) / LANES) : v1_step;
  assign clr_addr = (state == ST_CLR) ? cidx : sc1_addr;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      lane_clr[l] = (state == ST_CLR) || (sc1_valid && (sc1_lane == L_W'(l)));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    hvd_lane #(.NBINS(NBINS), .LANES(LANES), .LANE(l), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .s1_valid(v1_valid), .rd_addr(lane_rd),
      .dx(dx1), .dy(dy1), .tol(tol_i), .clr_en(lane_clr[l]),
      .clr_addr(clr_addr), .rd_data_o(lane_cnt[l])
    );
  end

  logic [CNT_W-1:0] sel_cnt;
  assign sel_cnt = lane_cnt[sc1_lane];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_CLR;    cidx <= '0;      frame_q <= 1'b0;
      x_q <= '0;          y_q <= '0;       npts <= '0;       ovf_q <= 1'b0;
      vpx <= '0;          vpy <= '0;       pidx <= '0;       step <= '0;
      v1_valid <= 1'b0;   v1_step <= '0;   drain <= 1'b0;
      sidx <= '0;         sc1_valid <= 1'b0; sc1_bin <= '0;
      res_valid_o <= 1'b0; res_bin_o <= '0; res_count_o <= '0; done_o <= 1'b0;
    end else begin
      frame_q     <= frame_i;
      v1_valid    <= 1'b0;
      sc1_valid   <= 1'b0;
      res_valid_o <= 1'b0;
      done_o      <= 1'b0;
      unique case (state)
        ST_CLR: begin
          cidx <= cidx + 1'b1;
          if (cidx == S_W'(STEPS - 1)) state <= ST_IDLE;
        end
        ST_IDLE: if (frame_start_evt) begin
          state <= ST_CAP; x_q <= '0; y_q <= '0; npts <= '0; ovf_q <= 1'b0;
        end
        ST_CAP: begin
          if (!frame_i) begin
            vpx <= vp_x_i; vpy <= vp_y_i; pidx <= '0; step <= '0; drain <= 1'b0;
            state <= (npts == '0) ? ST_DRAIN : ST_VOTE;
          end else if (de_i) begin
            if (x_q == X_W'(IMG_W - 1)) begin
              x_q <= '0; y_q <= y_q + 1'b1;
            end else x_q <= x_q + 1'b1;
            if (edge_i) begin
              if (npts < CNT_W'(MAX_PTS)) npts <= npts + 1'b1;
              else ovf_q <= 1'b1;
            end
          end
        end
        ST_VOTE: begin
          v1_valid <= 1'b1;
          v1_step  <= step;
          if (step == S_W'(STEPS - 1)) begin
            step <= '0;
            pidx <= pidx + 1'b1;
            if (pidx == npts - 1'b1) state <= ST_DRAIN;
          end else step <= step + 1'b1;
        end
        ST_DRAIN: begin
          drain <= 1'b1;
          if (drain) begin state <= ST_SCAN; sidx <= '0; end
        end
        ST_SCAN: begin
          sc1_valid <= 1'b1;
          sc1_bin   <= sidx;
          sidx      <= sidx + 1'b1;
          if (sidx == BIN_W'(NBINS - 1)) state <= ST_FLUSH;
        end
        ST_FLUSH: state <= ST_FIN;
        ST_FIN: begin done_o <= 1'b1; state <= ST_IDLE; end
        default: state <= ST_IDLE;
      endcase
      if (sc1_valid) begin
        res_valid_o <= (sel_cnt >= thr_i);
        res_bin_o   <= sc1_bin;
        res_count_o <= sel_cnt;
      end
    end
  end
endmodule

// File: rtl/hvd_checker.sv
module hvd_checker #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             ovf_o,
  input logic             res_valid_o,
  input logic [CNT_W-1:0] res_count_o,
  input logic [CNT_W-1:0] thr_i,
  input logic             done_o,
  input logic             frame_start_evt,
  input logic             frame_end_evt,
  input logic             pix_accept
);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_report_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> busy_o);
  assert_report_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (res_count_o >= thr_i));
  assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  assert_busy_after_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_evt |=> busy_o);
  assert_no_pixel_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_accept |-> !busy_o);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !frame_start_evt) |=> ovf_o);
  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_evt |=> !ovf_o);
endmodule

bind hvd_line_detector hvd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .ovf_o(ovf_o),
  .res_valid_o(res_valid_o), .res_count_o(res_count_o), .thr_i(thr_i),
  .done_o(done_o), .frame_start_evt(frame_start_evt),
  .frame_end_evt(frame_end_evt), .pix_accept(pix_accept)
);

// File: tb/hvd_line_detector_tb_top.sv
`timescale 1ns/1ps
module hvd_line_detector_tb_top;
  localparam int IMG_W = 16, IMG_H = 16, NBINS = 16, LANES = 16, MAX_PTS = 8;
  localparam int X_W = 4, Y_W = 4, CNT_W = 4, BIN_W = 4;
  localparam int NPIX = IMG_W * IMG_H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic frame = 0, de = 0, edg = 0;
  logic [X_W-1:0] vx = '0;
  logic [Y_W-1:0] vy = '0;
  logic [2:0] tol = '0;
  logic [CNT_W-1:0] thr = '0;
  logic busy, ovf, res_valid, done;
  logic [BIN_W-1:0] res_bin;
  logic [CNT_W-1:0] res_count;

  hvd_line_detector #(.IMG_W(IMG_W), .IMG_H(IMG_H), .NBINS(NBINS), .LANES(LANES),
                      .MAX_PTS(MAX_PTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_i(frame), .de_i(de), .edge_i(edg),
    .vp_x_i(vx), .vp_y_i(vy), .tol_i(tol), .thr_i(thr), .busy_o(busy),
    .ovf_o(ovf), .res_valid_o(res_valid), .res_bin_o(res_bin),
    .res_count_o(res_count), .done_o(done));

  int n_cmp = 0, n_bad = 0;
  bit got_f [NBINS];
  int got_c [NBINS];
  int exp_c [NBINS];
  bit exp_ovf;
  int n_done = 0, n_res = 0;
  bit ovf_at_start;

  always @(negedge clk) begin
    if (res_valid) begin got_f[res_bin] = 1'b1; got_c[res_bin] = int'(res_count); n_res++; end
    if (done) n_done++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model built from the requirement text
  task automatic model(input logic [NPIX-1:0] pic, input int px, input int py, input int t);
    int xs [MAX_PTS];
    int ys [MAX_PTS];
    int n = 0;
    exp_ovf = 0;
    for (int p = 0; p < NPIX; p++) if (pic[p]) begin
      if (n < MAX_PTS) begin xs[n] = p % IMG_W; ys[n] = p / IMG_W; n++; end
      else exp_ovf = 1;
    end
    for (int k = 0; k < NBINS; k++) begin
      real a;
      longint c, s, r, lim;
      a = 3.141592653589793 * k / NBINS;
      c = longint'($rtoi($floor(511.0 * $cos(a) + 0.5)));
      s = longint'($rtoi($floor(511.0 * $sin(a) + 0.5)));
      lim = 512 * t + 256;
      exp_c[k] = 0;
      for (int i = 0; i < n; i++) begin
        r = (xs[i] - px) * c + (ys[i] - py) * s;
        if (r * r <= lim * lim) exp_c[k]++;
      end
    end
  endtask

  task automatic run_frame(input logic [NPIX-1:0] pic, input int px, input int py,
                           input int t, input int th, input bit intrude);
    for (int k = 0; k < NBINS; k++) begin got_f[k] = 0; got_c[k] = -1; end
    n_done = 0; n_res = 0;
    model(pic, px, py, t);
    @(negedge clk);
    vx = X_W'(px); vy = Y_W'(py); tol = 3'(t); thr = CNT_W'(th);
    frame = 1;
    @(negedge clk);
    @(negedge clk);
    ovf_at_start = ovf;
    for (int p = 0; p < NPIX; p++) begin
      de = 1; edg = pic[p];
      @(negedge clk);
    end
    de = 0; edg = 0; frame = 0;
    @(negedge clk);
    if (intrude) begin
      @(negedge clk);
      chk(busy == 1'b1, "R7 busy after frame close", int'(busy), 1);
      frame = 1;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin de = 1; edg = 1; @(negedge clk); end
      de = 0; edg = 0; frame = 0;
    end
    while (n_done == 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(input string tag, input int th);
    chk(n_done == 1, {tag, " single done"}, n_done, 1);
    for (int k = 0; k < NBINS; k++) begin
      bit want;
      want = exp_c[k] >= th;
      chk(got_f[k] == want, $sformatf("%s bin %0d reported", tag, k), int'(got_f[k]), int'(want));
      if (want) chk(got_c[k] == exp_c[k], $sformatf("%s bin %0d count", tag, k), got_c[k], exp_c[k]);
    end
    chk(ovf == exp_ovf, {tag, " overflow flag"}, int'(ovf), int'(exp_ovf));
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(busy == 0, "R1 busy after reset", int'(busy), 0);
    chk(ovf == 0, "R1 ovf after reset", int'(ovf), 0);
    chk(res_valid == 0, "R1 res_valid after reset", int'(res_valid), 0);
    chk(done == 0, "R1 done after reset", int'(done), 0);
  endtask

  task automatic t_vertical();
    logic [NPIX-1:0] pic = '0;
    for (int y = 0; y < 8; y++) pic[y * IMG_W + 8] = 1;
    run_frame(pic, 8, 4, 0, 3, 0);
    compare("R2 R3 vertical line", 3);
    chk(got_c[0] == 8, "R4 bin0 back-to-back increments", got_c[0], 8);
  endtask

  task automatic t_tolerance();
    logic [NPIX-1:0] pic = '0;
    for (int y = 0; y < 6; y++) pic[y * IMG_W + 9] = 1;
    run_frame(pic, 8, 4, 1, 1, 0);
    compare("R3 tol one", 1);
    chk(got_c[0] == 6, "R3 offset line within tol 1", got_c[0], 6);
    run_frame(pic, 8, 4, 0, 1, 0);
    compare("R3 tol zero", 1);
    chk(got_f[0] == 0, "R3 offset line outside tol 0", int'(got_f[0]), 0);
  endtask

  task automatic t_vp_latch();
    logic [NPIX-1:0] pic = '0;
    for (int y = 0; y < 8; y++) pic[y * IMG_W + 8] = 1;
    run_frame(pic, 3, 4, 0, 1, 0);
    compare("R9 moved vanishing point", 1);
    chk(got_f[0] == 0, "R9 line misses new origin", int'(got_f[0]), 0);
  endtask

  task automatic t_diagonal();
    logic [NPIX-1:0] pic = '0;
    for (int i = 0; i < 8; i++) pic[i * IMG_W + 4 + i] = 1;
    run_frame(pic, 8, 4, 0, 8, 0);
    compare("R5 threshold equal", 8);
    chk(got_f[12] == 1 && got_c[12] == 8, "R5 diagonal bin12 at thr", got_c[12], 8);
    run_frame(pic, 8, 4, 0, 9, 0);
    compare("R5 threshold above", 9);
    chk(n_res == 0, "R5 nothing above max", n_res, 0);
  endtask

  task automatic t_overflow();
    logic [NPIX-1:0] pic = '0;
    for (int x = 0; x < 12; x++) pic[2 * IMG_W + x] = 1;
    run_frame(pic, 5, 2, 0, 1, 0);
    compare("R8 overflow frame", 1);
    chk(ovf == 1, "R8 ovf set", int'(ovf), 1);
    repeat (10) @(negedge clk);
    chk(ovf == 1, "R8 ovf sticky", int'(ovf), 1);
  endtask

  task automatic t_empty();
    logic [NPIX-1:0] pic = '0;
    run_frame(pic, 7, 7, 0, 0, 0);
    chk(ovf_at_start == 0, "R8 ovf cleared on frame start", int'(ovf_at_start), 0);
    compare("R6 empty frame", 0);
    chk(n_res == NBINS, "R6 all bins reported", n_res, NBINS);
  endtask

  task automatic t_intrude();
    logic [NPIX-1:0] pic = '0;
    pic[1 * IMG_W + 2] = 1; pic[5 * IMG_W + 6] = 1; pic[9 * IMG_W + 10] = 1;
    run_frame(pic, 6, 5, 0, 1, 1);
    compare("R7 frame during busy", 1);
    repeat (40) @(negedge clk);
    chk(n_done == 1, "R7 ignored frame gives no done", n_done, 1);
    chk(busy == 0, "R7 idle after ignored frame", int'(busy), 0);
  endtask

  initial begin
    t_reset();
    t_vertical();
    t_tolerance();
    t_vp_latch();
    t_diagonal();
    t_overflow();
    t_empty();
    t_intrude();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule